// File: doc/BRIEF.md
# Stop-and-Wait Link Controller

This block is a hardware state machine that opens, uses and closes a simple point-to-point connection carried in raw Ethernet frames. Each frame it sends or receives is described by a one-byte type code and a one-byte payload. A connect switch opens and closes the link through a handshake. A data switch streams one payload byte at a time, and each byte must be acknowledged before the next is sent. A drop switch makes the block deaf to incoming frames, which is used to provoke timeouts on purpose.

The block presents at most one outgoing frame at a time on a request/ready pair: type, payload, a 16-bit sequence number and a 16-bit acknowledge number. An outside framer, MAC and DMA turn this into a wire frame. Received frames arrive as a one-cycle strobe with their type and payload. A retransmission timer resends the last connection or data frame when no answer comes. After a fixed number of unanswered resends the block gives up and falls back to the disconnected state.

Top module: `saw_link_ctrl`

## Requirements
- R1: After reset, tx_req, link_up, data_ok, syn_sent, conn_closed and aborted are 0 and led is 0x00.
- R2: Once raised, tx_req stays high with tx_type, tx_payload, tx_seq and tx_ack unchanged until tx_ready is high at a clock edge, and it is low in the cycle after that edge. A received frame that arrives while tx_req is high is ignored entirely.
- R3: A rising edge of connect_sw while link_up is 0 sends exactly one SYN (type 0x01, payload 0x00), sets syn_sent and clears aborted. While link_up is 1, the same edge sends nothing and sets data_ok.
- R4: A falling edge of connect_sw while syn_sent is 1 sends a FIN (0x02) and clears data_ok and syn_sent. While syn_sent is 0, the same edge sends nothing.
- R5: A received SYN (0x01) sets link_up and is answered with SYN-ACK (0x05). A received SYN-ACK sets link_up and data_ok and is answered with ACK (0x04). Both clear conn_closed.
- R6: A received FIN (0x02) clears link_up and data_ok and is answered with FIN-ACK (0x06). A received FIN-ACK clears link_up and is answered with ACK (0x04).
- R7: A received ACK (0x04) is not answered. It sets data_ok when link_up is 1 and sets conn_closed when link_up is 0.
- R8: A received DATA frame (0x08) copies its payload to led and is answered with DATA-ACK (0x0C) carrying the same payload. A received DATA-ACK sets data_ok and is not answered.
- R9: Every new frame carries tx_seq one higher than the previous new frame, starting at 0. tx_ack equals the number of accepted frames received so far with one of the seven known codes, counting the frame being answered.
- R10: While data_sw and data_ok are both 1, a DATA frame (0x08) is sent once data_sw has been high for PACE_CYCLES cycles since the switch rose or since the previous DATA frame. Its payload is one more than the previous DATA payload, starting at 0x01. Sending it clears data_ok.
- R11: When the handshake of a SYN, FIN or DATA frame completes at edge k and no frame is accepted afterwards, the same frame (same type, payload, sequence and acknowledge numbers) is requested again at edge k+TIMEOUT_CYCLES.
- R12: When the timer expires after RETRY_LIMIT retransmissions with no accepted frame in between, no frame is sent. link_up, data_ok and syn_sent are cleared and aborted is set.
- R13: Any accepted received frame stops the timer and clears the retry count. A frame with an unknown type code is not answered and does not change the acknowledge number.
- R14: While drop_sw is 1, received frames change nothing: led, flags and acknowledge number stay as they are, no answer is sent, and a running timer keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| connect_sw | input | 1 | Connect switch; rising edge opens, falling edge closes |
| data_sw | input | 1 | Enables paced sending of data bytes |
| drop_sw | input | 1 | When high, received frames are discarded |
| rx_valid | input | 1 | One-cycle strobe for a received frame |
| rx_type | input | 8 | Type code of the received frame |
| rx_payload | input | 8 | Payload byte of the received frame |
| tx_ready | input | 1 | Transmitter accepts the pending frame at this edge |
| tx_req | output | 1 | A frame is waiting to be sent |
| tx_type | output | 8 | Type code of the pending frame |
| tx_payload | output | 8 | Payload byte of the pending frame |
| tx_seq | output | SEQ_W | Sequence number of the pending frame |
| tx_ack | output | SEQ_W | Acknowledge number of the pending frame |
| led | output | 8 | Payload of the last received data frame |
| link_up | output | 1 | Connection is open |
| data_ok | output | 1 | A new data frame may be sent |
| syn_sent | output | 1 | This side opened the connection |
| conn_closed | output | 1 | Closing handshake finished |
| aborted | output | 1 | Retry limit was reached |

## Verification
The bench builds the block with TIMEOUT_CYCLES=24, PACE_CYCLES=10 and RETRY_LIMIT=3, in place of the multi-million-cycle defaults. With these values the exact retransmission instant and the exact pacing delay can be counted cycle by cycle. The full retry ladder up to an abort also fits in about a hundred cycles, so the timeout path is driven to its end rather than only to its first resend. Randomised data bytes, unknown type codes and grant delays run between the directed handshake, drop and busy-slot cases.

// File: rtl/saw_link_ctrl.sv
module saw_link_ctrl #(
  parameter int TIMEOUT_CYCLES = 3000000,
  parameter int PACE_CYCLES    = 1000000,
  parameter int RETRY_LIMIT    = 50,
  parameter int SEQ_W          = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             connect_sw,
  input  logic             data_sw,
  input  logic             drop_sw,
  input  logic             rx_valid,
  input  logic [7:0]       rx_type,
  input  logic [7:0]       rx_payload,
  input  logic             tx_ready,
  output logic             tx_req,
  output logic [7:0]       tx_type,
  output logic [7:0]       tx_payload,
  output logic [SEQ_W-1:0] tx_seq,
  output logic [SEQ_W-1:0] tx_ack,
  output logic [7:0]       led,
  output logic             link_up,
  output logic             data_ok,
  output logic             syn_sent,
  output logic             conn_closed,
  output logic             aborted
);
  localparam logic [7:0] C_SYN    = 8'h01;
  localparam logic [7:0] C_FIN    = 8'h02;
  localparam logic [7:0] C_ACK    = 8'h04;
  localparam logic [7:0] C_SYNACK = 8'h05;
  localparam logic [7:0] C_FINACK = 8'h06;
  localparam logic [7:0] C_DATA   = 8'h08;
  localparam logic [7:0] C_DACK   = 8'h0C;
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int PW = $clog2(PACE_CYCLES + 1);
  localparam int RW = $clog2(RETRY_LIMIT + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [PW-1:0] P_FULL = PW'(PACE_CYCLES);
  localparam logic [RW-1:0] R_MAX  = RW'(RETRY_LIMIT);

  logic             conn_seen, tmr_on;
  logic [TW-1:0]    tmr_cnt;
  logic [PW-1:0]    pace_cnt;
  logic [RW-1:0]    retry_cnt;
  logic [7:0]       data_byte;
  logic [SEQ_W-1:0] seq_num, ack_num;

  logic slot_free, rx_take, conn_evt, expired, retx, data_go, sent, timed, known;
  logic [SEQ_W-1:0] ack_next;

  assign slot_free = !tx_req;
  assign rx_take   = slot_free && rx_valid && !drop_sw;
  assign conn_evt  = slot_free && !rx_take && (connect_sw != conn_seen);
  assign expired   = tmr_on && (tmr_cnt == '0);
  assign retx      = slot_free && !rx_take && !conn_evt && expired;
  assign data_go   = slot_free && !rx_take && !conn_evt && !expired &&
                     data_sw && data_ok && (pace_cnt == P_FULL);
  assign sent      = tx_req && tx_ready;
  assign timed     = (tx_type == C_SYN) || (tx_type == C_FIN) || (tx_type == C_DATA);
  assign known     = rx_type inside {C_SYN, C_FIN, C_ACK, C_SYNACK, C_FINACK, C_DATA, C_DACK};
  assign ack_next  = ack_num + SEQ_W'(rx_take && known);

  logic       ld;
  logic [7:0] ld_type, ld_pay;

  always_comb begin
    ld      = 1'b0;
    ld_type = C_ACK;
    ld_pay  = 8'h00;
    if (rx_take) begin
      case (rx_type)
        C_SYN:    begin ld = 1'b1; ld_type = C_SYNACK; end
        C_SYNACK: begin ld = 1'b1; ld_type = C_ACK;    end
        C_FIN:    begin ld = 1'b1; ld_type = C_FINACK; end
        C_FINACK: begin ld = 1'b1; ld_type = C_ACK;    end
        C_DATA:   begin ld = 1'b1; ld_type = C_DACK; ld_pay = rx_payload; end
        default:  ;
      endcase
    end else if (conn_evt) begin
      if (connect_sw && !link_up) begin
        ld = 1'b1; ld_type = C_SYN;
      end else if (!connect_sw && syn_sent) begin
        ld = 1'b1; ld_type = C_FIN;
      end
    end else if (data_go) begin
      ld = 1'b1; ld_type = C_DATA; ld_pay = data_byte + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_req      <= 1'b0;
      tx_type     <= 8'h00;
      tx_payload  <= 8'h00;
      tx_seq      <= '0;
      tx_ack      <= '0;
      led         <= 8'h00;
      link_up     <= 1'b0;
      data_ok     <= 1'b0;
      syn_sent    <= 1'b0;
      conn_closed <= 1'b0;
      aborted     <= 1'b0;
      conn_seen   <= 1'b0;
      tmr_on      <= 1'b0;
      tmr_cnt     <= '0;
      pace_cnt    <= '0;
      retry_cnt   <= '0;
      data_byte   <= 8'h00;
      seq_num     <= '0;
      ack_num     <= '0;
    end else begin
      if (sent) begin
        tx_req <= 1'b0;
        if (timed) begin
          tmr_on  <= 1'b1;
          tmr_cnt <= T_LOAD;
        end
      end else if (tmr_on && tmr_cnt != '0) begin
        tmr_cnt <= tmr_cnt - TW'(1);
      end

      if (!data_sw) pace_cnt <= '0;
      else if (pace_cnt != P_FULL) pace_cnt <= pace_cnt + PW'(1);

      if (ld) begin
        tx_req     <= 1'b1;
        tx_type    <= ld_type;
        tx_payload <= ld_pay;
        tx_seq     <= seq_num;
        tx_ack     <= ack_next;
        seq_num    <= seq_num + SEQ_W'(1);
      end

      if (rx_take) begin
        tmr_on    <= 1'b0;
        retry_cnt <= '0;
        ack_num   <= ack_next;
        case (rx_type)
          C_SYN:    begin link_up <= 1'b1; conn_closed <= 1'b0; end
          C_SYNACK: begin link_up <= 1'b1; conn_closed <= 1'b0; data_ok <= 1'b1; end
          C_FIN:    begin link_up <= 1'b0; data_ok <= 1'b0; end
          C_FINACK: link_up <= 1'b0;
          C_ACK:    if (link_up) data_ok <= 1'b1; else conn_closed <= 1'b1;
          C_DATA:   led <= rx_payload;
          C_DACK:   data_ok <= 1'b1;
          default:  ;
        endcase
      end else if (conn_evt) begin
        conn_seen <= connect_sw;
        if (connect_sw && link_up) data_ok <= 1'b1;
        else if (connect_sw) begin
          syn_sent <= 1'b1;
          aborted  <= 1'b0;
        end else if (syn_sent) begin
          syn_sent <= 1'b0;
          data_ok  <= 1'b0;
        end
      end else if (retx) begin
        tmr_on <= 1'b0;
        if (retry_cnt == R_MAX) begin
          link_up   <= 1'b0;
          data_ok   <= 1'b0;
          syn_sent  <= 1'b0;
          aborted   <= 1'b1;
          retry_cnt <= '0;
        end else begin
          retry_cnt <= retry_cnt + RW'(1);
          tx_req    <= 1'b1;
        end
      end else if (data_go) begin
        data_byte <= data_byte + 8'd1;
        data_ok   <= 1'b0;
        pace_cnt  <= '0;
      end
    end
  end
endmodule

// File: rtl/saw_link_chk.sv
module saw_link_chk #(
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_req,
  input logic             tx_ready,
  input logic             drop_sw,
  input logic             rx_valid,
  input logic             aborted,
  input logic             link_up,
  input logic             data_ok,
  input logic [7:0]       tx_type,
  input logic [7:0]       tx_payload,
  input logic [7:0]       led,
  input logic [SEQ_W-1:0] tx_seq,
  input logic [SEQ_W-1:0] tx_ack
);
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ready |=> tx_req && $stable(tx_type) && $stable(tx_payload) &&
                            $stable(tx_seq) && $stable(tx_ack));

  assert_req_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_ready |=> !tx_req);

  assert_seq_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> (tx_seq == $past(tx_seq)) || (tx_seq == $past(tx_seq) + SEQ_W'(1)));

  assert_data_clears_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) && (tx_type == 8'h08) && (tx_seq != $past(tx_seq)) |-> !data_ok);

  assert_abort_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aborted) |-> !link_up && !data_ok && !tx_req);

  assert_drop_keeps_led_R14: assert property (@(posedge clk) disable iff (!rst_n)
    drop_sw && rx_valid |=> $stable(led));
endmodule

bind saw_link_ctrl saw_link_chk #(.SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/saw_link_ctrl_bench.sv
`timescale 1ns/1ps
module saw_link_ctrl_bench;
  localparam int TO = 24, PACE = 10, RL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic connect_sw = 0, data_sw = 0, drop_sw = 0, rx_valid = 0, tx_ready = 0;
  logic [7:0] rx_type = 0, rx_payload = 0;
  logic tx_req, link_up, data_ok, syn_sent, conn_closed, aborted;
  logic [7:0] tx_type, tx_payload, led;
  logic [15:0] tx_seq, tx_ack;

  int n_tests = 0, n_fail = 0, cyc = 0, exp_seq = 0, exp_ack = 0;
  bit done = 0;
  logic [7:0] g_type, g_pay, led_exp;
  logic [15:0] g_seq, g_ack;

  always #4 clk = ~clk;

  saw_link_ctrl #(.TIMEOUT_CYCLES(TO), .PACE_CYCLES(PACE), .RETRY_LIMIT(RL), .SEQ_W(16))
  u_saw_link_ctrl (
    .clk(clk), .rst_n(rst_n), .connect_sw(connect_sw), .data_sw(data_sw), .drop_sw(drop_sw),
    .rx_valid(rx_valid), .rx_type(rx_type), .rx_payload(rx_payload), .tx_ready(tx_ready),
    .tx_req(tx_req), .tx_type(tx_type), .tx_payload(tx_payload), .tx_seq(tx_seq), .tx_ack(tx_ack),
    .led(led), .link_up(link_up), .data_ok(data_ok), .syn_sent(syn_sent),
    .conn_closed(conn_closed), .aborted(aborted));

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] reply_of(input logic [7:0] t);
    case (t)
      8'h01: return 8'h05;
      8'h05: return 8'h04;
      8'h02: return 8'h06;
      8'h06: return 8'h04;
      8'h08: return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit is_known(input logic [7:0] t);
    return t inside {8'h01, 8'h02, 8'h04, 8'h05, 8'h06, 8'h08, 8'h0C};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 20000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic send_rx(input logic [7:0] t, input logic [7:0] p);
    rx_valid = 1; rx_type = t; rx_payload = p;
    @(negedge clk);
    rx_valid = 0;
    if (!drop_sw && is_known(t)) exp_ack++;
  endtask

  task automatic grab(input string req, input int dly);
    int w = 0;
    bit held = 1;
    while (!tx_req && w < 400) begin @(negedge clk); w++; end
    check(req, "request raised", tx_req, 1);
    g_type = tx_type; g_pay = tx_payload; g_seq = tx_seq; g_ack = tx_ack;
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      if (!tx_req || tx_type != g_type || tx_seq != g_seq || tx_payload != g_pay || tx_ack != g_ack) held = 0;
    end
    check("R2", "request held until ready", held, 1);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    check("R2", "request dropped after grant", tx_req, 0);
  endtask

  task automatic expect_frame(input string req, input logic [7:0] t, input logic [7:0] p);
    grab(req, $urandom_range(0, 3));
    check(req, "frame type", g_type, t);
    check(req, "frame payload", g_pay, p);
    check("R9", "sequence number", g_seq, exp_seq);
    check("R9", "ack number", g_ack, exp_ack);
    exp_seq++;
  endtask

  task automatic expect_retx(input logic [7:0] t, input logic [7:0] p, input int s, input int a);
    grab("R11", $urandom_range(0, 2));
    check("R11", "resent type", g_type, t);
    check("R11", "resent payload", g_pay, p);
    check("R11", "resent sequence", g_seq, s);
    check("R11", "resent ack", g_ack, a);
  endtask

  task automatic measure_timeout(input string req);
    int cnt = 0;
    while (!tx_req && cnt < 200) begin @(negedge clk); rx_valid = 0; cnt++; end
    check(req, "cycles to retransmission", cnt, TO);
  endtask

  task automatic quiet(input string req, input int n);
    bit q = 1;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (tx_req) q = 0; end
    check(req, "no frame requested", q, 1);
  endtask

  initial begin
    int fin_seq, fin_ack, cnt;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "tx_req in reset", tx_req, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "tx_req", tx_req, 0);
    check("R1", "link_up", link_up, 0);
    check("R1", "data_ok", data_ok, 0);
    check("R1", "flags", {syn_sent, conn_closed, aborted}, 0);
    check("R1", "led", led, 0);

    // open from this side, lose the first answer
    connect_sw = 1;
    expect_frame("R3", 8'h01, 8'h00);
    check("R3", "syn_sent", syn_sent, 1);
    measure_timeout("R11");
    expect_retx(8'h01, 8'h00, 0, 0);
    send_rx(8'h05, 8'h00);
    expect_frame("R5", reply_of(8'h05), 8'h00);
    check("R5", "link_up after SYN-ACK", link_up, 1);
    check("R5", "data_ok after SYN-ACK", data_ok, 1);

    // paced data
    data_sw = 1;
    cnt = 0;
    while (!tx_req && cnt < 100) begin @(negedge clk); cnt++; end
    check("R10", "pacing delay", cnt, PACE + 1);
    expect_frame("R10", 8'h08, 8'h01);
    check("R10", "data_ok cleared", data_ok, 0);
    data_sw = 0;
    send_rx(8'h0C, 8'h01);
    check("R8", "data_ok after DATA-ACK", data_ok, 1);
    quiet("R13", TO + 4);
    data_sw = 1;
    expect_frame("R10", 8'h08, 8'h02);
    data_sw = 0;
    send_rx(8'h0C, 8'h02);

    // random received traffic
    led_exp = led;
    for (int it = 0; it < 30; it++) begin
      int k = $urandom_range(0, 3);
      logic [7:0] p = 8'($urandom);
      if (k < 2) begin
        send_rx(8'h08, p);
        led_exp = p;
        expect_frame("R8", reply_of(8'h08), p);
        check("R8", "led follows data", led, p);
      end else if (k == 2) begin
        send_rx(8'h04, 8'h00);
        quiet("R7", 3);
        check("R7", "data_ok after ACK with link up", data_ok, 1);
      end else begin
        send_rx(8'h30 + 8'($urandom_range(0, 7)), p);
        quiet("R13", 3);
      end
    end

    // drop switch
    drop_sw = 1;
    send_rx(8'h08, led_exp ^ 8'hFF);
    quiet("R14", 4);
    check("R14", "led unchanged", led, led_exp);
    check("R14", "link_up unchanged", link_up, 1);
    drop_sw = 0;

    // frame received while a request is pending
    send_rx(8'h01, 8'h00);
    check("R5", "request pending", tx_req, 1);
    send_rx(8'h08, 8'h77);
    exp_ack--;
    expect_frame("R5", reply_of(8'h01), 8'h00);
    quiet("R2", 4);
    check("R2", "led unchanged by ignored frame", led, led_exp);

    // close from this side and let the retries run out
    connect_sw = 0;
    fin_seq = exp_seq; fin_ack = exp_ack;
    expect_frame("R4", 8'h02, 8'h00);
    check("R4", "data_ok cleared by FIN", data_ok, 0);
    check("R4", "syn_sent cleared", syn_sent, 0);
    drop_sw = 1;
    rx_valid = 1; rx_type = 8'h06; rx_payload = 0;
    measure_timeout("R14");
    drop_sw = 0;
    expect_retx(8'h02, 8'h00, fin_seq, fin_ack);
    for (int r = 1; r < RL; r++) begin
      measure_timeout("R11");
      expect_retx(8'h02, 8'h00, fin_seq, fin_ack);
    end
    quiet("R12", TO + 3);
    check("R12", "aborted", aborted, 1);
    check("R12", "link_up", link_up, 0);
    check("R12", "data_ok", data_ok, 0);

    // reopen, then peer closes
    connect_sw = 1;
    expect_frame("R3", 8'h01, 8'h00);
    check("R3", "aborted cleared", aborted, 0);
    send_rx(8'h01, 8'h00);
    expect_frame("R5", reply_of(8'h01), 8'h00);
    check("R5", "link_up after SYN", link_up, 1);
    send_rx(8'h02, 8'h00);
    expect_frame("R6", reply_of(8'h02), 8'h00);
    check("R6", "link_up after FIN", link_up, 0);
    check("R6", "data_ok after FIN", data_ok, 0);
    send_rx(8'h06, 8'h00);
    expect_frame("R6", reply_of(8'h06), 8'h00);
    check("R6", "link_up after FIN-ACK", link_up, 0);
    send_rx(8'h04, 8'h00);
    quiet("R7", 3);
    check("R7", "conn_closed after ACK with link down", conn_closed, 1);

    // connect edge with link already up, then fall without own SYN
    connect_sw = 0;
    expect_frame("R4", 8'h02, 8'h00);
    send_rx(8'h01, 8'h00);
    expect_frame("R5", reply_of(8'h01), 8'h00);
    check("R5", "conn_closed cleared", conn_closed, 0);
    connect_sw = 1;
    quiet("R3", 4);
    check("R3", "data_ok with link up", data_ok, 1);
    check("R3", "syn_sent stays low", syn_sent, 0);
    connect_sw = 0;
    quiet("R4", TO + 4);
    check("R4", "data_ok kept", data_ok, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule